// File: doc/BRIEF.md
# PWM Pin Override Stage

This block takes per-pair duty-compare levels and turns them into the final high-side and low-side levels for a set of PWM output pairs (four by default). Each pair runs either in complementary mode, where the low pin is the inverse of the high pin and a programmable dead time delays every rising edge, or in independent mode, where both pins follow the pair's duty signal with no dead time. On top of either mode, software can force any pin through an override word. Each pin has an enable bit and a level bit in that word.

Override changes can apply on the next clock, or they can wait for a time-base event: a counter-zero pulse, or in center-aligned counting also a period-match pulse. The register write port is a plain strobe with no back-pressure. A write is accepted in every cycle in which `wr_en` is high, so there is no ready signal and no write is ever stalled or dropped. All pin outputs are active-high and registered.

Top module: `pwm_pin_override`

## Requirements
- R1: While `rst_n` is low every pin output is 0. After reset all pairs are complementary, all overrides are disabled, the dead time is 0 and synchronized override is off.
- R2: In complementary mode with no override and zero dead time, `pin_hi[k]` equals `duty_in[k]` and `pin_lo[k]` equals its inverse, one clock after the duty input is sampled.
- R3: In complementary mode a pin's rising edge comes dead-time+1 clocks after its source rises, while its falling edge comes after one clock. The two pins of a complementary pair are never both 1.
- R4: Control register (address 1) bit k = 1 puts pair k in independent mode. Both pins then follow `duty_in[k]` after one clock with no dead time, and both may be 1 together.
- R5: Override word (address 0): bit 8+i enables pin i and bit i gives its forced level, where pin 2k+1 is the high pin and pin 2k the low pin of pair k. In independent mode an enabled pin outputs its level bit.
- R6: In complementary mode an enabled high pin takes its level bit. An enabled low pin with level 1 outputs the inverse of the high pin's source, and with level 0 it outputs 0. A low pin that is not enabled outputs the inverse of the high pin's source.
- R7: Dead-time delay (address 2, bits 7:0, in clocks) still applies to overridden pins in complementary mode.
- R8: With control bit NPAIRS (bit 4 by default) clear, a written override word reaches the pins two clocks after the write is sampled.
- R9: With that bit set and `center_mode` low, a written override word takes effect only at a `tb_zero` pulse. A `tb_period` pulse is ignored.
- R10: With that bit set and `center_mode` high, a pending override word takes effect at either a `tb_zero` or a `tb_period` pulse.
- R11: An override write in the same cycle as a sync event takes effect at that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duty_in | input | NPAIRS | Raw duty-compare level per pair |
| tb_zero | input | 1 | Time-base counter-zero pulse |
| tb_period | input | 1 | Time-base period-match pulse |
| center_mode | input | 1 | Time base counts center-aligned |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 2 | Register select: 0 override, 1 control, 2 dead time |
| wr_data | input | 4*NPAIRS | Register write data |
| pin_hi | output | NPAIRS | High-side pin level per pair |
| pin_lo | output | NPAIRS | Low-side pin level per pair |

## Verification
The bench checks when a pending override word lands. A design that loads the shadow on period-match in edge-aligned counting would change the pins early. A design that ignores a write coinciding with an event would leave the old levels for a whole period. The bench also checks that a forced-active low pin follows the inverse of its high pin rather than a plain 1; getting that wrong would drive both transistors of a leg together. Finally, it times dead-time rising edges on overridden pins to catch a path that bypasses the delay.

// File: rtl/pwm_ovr_pkg.sv
package pwm_ovr_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_OVR = 2'd0,
    REG_CTL = 2'd1,
    REG_DT  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pwm_ovr_regs.sv
module pwm_ovr_regs
  import pwm_ovr_pkg::*;
#(
  parameter int NPAIRS = 4,
  parameter int DT_W   = 8,
  localparam int NPIN   = 2 * NPAIRS,
  localparam int WORD_W = 2 * NPIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              tb_zero,
  input  logic              tb_period,
  input  logic              center_mode,
  output logic [NPIN-1:0]   ovr_en,
  output logic [NPIN-1:0]   ovr_lvl,
  output logic [NPAIRS-1:0] indep,
  output logic [DT_W-1:0]   dead_cnt
);
  logic [WORD_W-1:0] shadow_q, shadow_nxt, active_q;
  logic              sync_q, sync_evt, wr_ovr;

  assign wr_ovr     = wr_en && (wr_addr == REG_OVR);
  assign shadow_nxt = wr_ovr ? wr_data : shadow_q;
  assign sync_evt   = tb_zero || (center_mode && tb_period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      sync_q   <= 1'b0;
      indep    <= '0;
      dead_cnt <= '0;
    end else begin
      shadow_q <= shadow_nxt;
      if (!sync_q || sync_evt) active_q <= shadow_nxt;
      if (wr_en && wr_addr == REG_CTL) begin
        indep  <= wr_data[NPAIRS-1:0];
        sync_q <= wr_data[NPAIRS];
      end
      if (wr_en && wr_addr == REG_DT) dead_cnt <= wr_data[DT_W-1:0];
    end
  end

  assign ovr_en  = active_q[WORD_W-1:NPIN];
  assign ovr_lvl = active_q[NPIN-1:0];

  // R9
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && !sync_evt) |=> $stable(active_q));
  // R8
  ovr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_q && wr_ovr) |=> (active_q == $past(wr_data)));
  // R11
  ovr_evt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && sync_evt && wr_ovr) |=> (active_q == $past(wr_data)));
endmodule

// File: rtl/pwm_pair_mux.sv
module pwm_pair_mux (
  input  logic duty,
  input  logic indep,
  input  logic en_h,
  input  logic en_l,
  input  logic lvl_h,
  input  logic lvl_l,
  output logic src_h,
  output logic src_l
);
  always_comb begin
    src_h = en_h ? lvl_h : duty;
    if (indep) src_l = en_l ? lvl_l : duty;
    else       src_l = en_l ? (lvl_l & ~src_h) : ~src_h;
  end
endmodule

// File: rtl/pwm_dt_delay.sv
module pwm_dt_delay #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src,
  input  logic [DT_W-1:0] dt,
  output logic            q
);
  logic [DT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !src) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (!q) begin
      if (cnt >= dt) begin
        q   <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3
  fall_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src |=> !q);
endmodule

// File: rtl/pwm_pin_override.sv
module pwm_pin_override
  import pwm_ovr_pkg::*;
#(
  parameter int NPAIRS = 4,
  parameter int DT_W   = 8,
  localparam int NPIN   = 2 * NPAIRS,
  localparam int WORD_W = 2 * NPIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPAIRS-1:0] duty_in,
  input  logic              tb_zero,
  input  logic              tb_period,
  input  logic              center_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [NPAIRS-1:0] pin_hi,
  output logic [NPAIRS-1:0] pin_lo
);
  logic [NPIN-1:0]   ovr_en, ovr_lvl;
  logic [NPAIRS-1:0] indep;
  logic [DT_W-1:0]   dead_cnt;

  pwm_ovr_regs #(.NPAIRS(NPAIRS), .DT_W(DT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tb_zero(tb_zero), .tb_period(tb_period),
    .center_mode(center_mode), .ovr_en(ovr_en), .ovr_lvl(ovr_lvl),
    .indep(indep), .dead_cnt(dead_cnt)
  );

  for (genvar k = 0; k < NPAIRS; k++) begin : g_pair
    logic            src_h, src_l;
    logic [DT_W-1:0] dt_eff;

    assign dt_eff = indep[k] ? '0 : dead_cnt;

    pwm_pair_mux u_mux (
      .duty(duty_in[k]), .indep(indep[k]),
      .en_h(ovr_en[2*k+1]), .en_l(ovr_en[2*k]),
      .lvl_h(ovr_lvl[2*k+1]), .lvl_l(ovr_lvl[2*k]),
      .src_h(src_h), .src_l(src_l)
    );

    pwm_dt_delay #(.DT_W(DT_W)) u_dt_h (
      .clk(clk), .rst_n(rst_n), .src(src_h), .dt(dt_eff), .q(pin_hi[k])
    );
    pwm_dt_delay #(.DT_W(DT_W)) u_dt_l (
      .clk(clk), .rst_n(rst_n), .src(src_l), .dt(dt_eff), .q(pin_lo[k])
    );

    // R3
    comp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !indep[k] |=> !(pin_hi[k] && pin_lo[k]));
  end

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> (pin_hi == '0 && pin_lo == '0));
endmodule

// File: tb/test_pwm_pin_override.sv
module test_pwm_pin_override;
  localparam int NPAIRS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  duty_in = '0;
  logic        tb_zero = 1'b0, tb_period = 1'b0, center_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pin_hi, pin_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [3:0] hi; logic [3:0] lo; string tag; } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  always #10 clk = ~clk;

  pwm_pin_override #(.NPAIRS(NPAIRS), .DT_W(8)) i_pwm_pin_override (
    .clk(clk), .rst_n(rst_n), .duty_in(duty_in), .tb_zero(tb_zero),
    .tb_period(tb_period), .center_mode(center_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pin_hi(pin_hi), .pin_lo(pin_lo)
  );

  // monitor: pops the expected item and compares it against the pins
  always @(chk_ev) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (pin_hi !== e.hi || pin_lo !== e.lo) begin
        errors++;
        $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b",
                 e.tag, pin_hi, pin_lo, e.hi, e.lo);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pins(input logic [3:0] hi, input logic [3:0] lo,
                             input string tag);
    exp_t e;
    e.hi = hi; e.lo = lo; e.tag = tag;
    exp_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse_zero();
    tb_zero = 1'b1; step(1); tb_zero = 1'b0;
  endtask

  task automatic pulse_period();
    tb_period = 1'b1; step(1); tb_period = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    duty_in = 4'b1111;
    step(3);
    expect_pins(4'b0000, 4'b0000, "R1 pins low in reset");
    duty_in = 4'b0000;
    rst_n = 1'b1;
    step(1);
    expect_pins(4'b0000, 4'b1111, "R1 R2 complementary after reset");

    duty_in = 4'b0101;
    step(1);
    expect_pins(4'b0101, 4'b1010, "R2 complementary follow");

    // R3 dead time 3: rise after 4 clocks, fall after 1
    wr(2'd2, 16'd3);
    duty_in = 4'b1111;
    step(3);
    expect_pins(4'b0101, 4'b0000, "R3 high rise delayed");
    step(1);
    expect_pins(4'b1111, 4'b0000, "R3 high rise after dead time");
    duty_in = 4'b0000;
    step(1);
    expect_pins(4'b0000, 4'b0000, "R3 low rise delayed");
    step(3);
    expect_pins(4'b0000, 4'b1111, "R3 low rise after dead time");
    wr(2'd2, 16'd0);

    // R4 independent mode
    wr(2'd1, 16'h000F);
    duty_in = 4'b0110;
    step(1);
    expect_pins(4'b0110, 4'b0110, "R4 independent both active");

    // R5 override in independent mode
    wr(2'd0, 16'h4B42);
    step(1);
    expect_pins(4'b0101, 4'b1110, "R5 R8 independent override");

    // R6 override in complementary mode
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h1F07);
    step(1);
    expect_pins(4'b0101, 4'b1010, "R6 complementary override");

    // R7 dead time on an overridden pin (dt=2)
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h9F87);
    step(2);
    expect_pins(4'b0101, 4'b0010, "R7 overridden high still delayed");
    step(1);
    expect_pins(4'b1101, 4'b0010, "R7 overridden high after dead time");
    wr(2'd2, 16'd0);

    // R8 immediate clear of override
    wr(2'd0, 16'h0000);
    step(1);
    expect_pins(4'b0110, 4'b1001, "R8 immediate override clear");

    // R9 synchronized override, edge-aligned
    wr(2'd1, 16'h0010);
    wr(2'd0, 16'hFF00);
    step(3);
    expect_pins(4'b0110, 4'b1001, "R9 pending override held");
    pulse_period();
    step(1);
    expect_pins(4'b0110, 4'b1001, "R9 period match ignored edge mode");
    pulse_zero();
    step(1);
    expect_pins(4'b0000, 4'b0000, "R9 applied at timer zero");

    // R10 center-aligned: period match applies
    center_mode = 1'b1;
    wr(2'd0, 16'hFFFF);
    step(2);
    expect_pins(4'b0000, 4'b0000, "R10 pending override held");
    pulse_period();
    step(1);
    expect_pins(4'b1111, 4'b0000, "R10 applied at period match");

    // R11 write coinciding with event
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0000; tb_zero = 1'b1;
    step(1);
    wr_en = 1'b0; tb_zero = 1'b0;
    step(1);
    expect_pins(4'b0110, 4'b1001, "R11 write at event takes effect");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule